// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block keeps a queue of loads, in program order, that may have run before the addresses of older stores were known. Each load takes a slot when it is dispatched. It records its address when it executes, and it leaves the queue at the head when it commits. Whenever a store's address resolves, the block compares that address with every executed load that is younger than the store. A matching load gets a sticky violation flag. Nothing is recovered at that moment.

When a flagged load reaches the commit point, the block emits a one-cycle trap pulse carrying the load's PC. It also empties the queue, because everything from that load onward must be refetched. A separate flush input removes every entry younger than a given age tag, for recovery that starts elsewhere in the pipeline. Ages are modular tags compared with wrap-around arithmetic. Addresses are compared at word granularity. DEPTH must be a power of two.

Top module: `load_violation_queue`

## Requirements
- R1: After reset the queue is empty: alloc_ready=1, commit_ready=0, trap_valid=0, alloc_slot=0.
- R2: An allocation takes the slot shown on alloc_slot, and slots are handed out in increasing order modulo DEPTH. When DEPTH entries are held, alloc_ready is 0 and an allocation attempt changes nothing.
- R3: An exec pulse on a held slot marks that load executed and records its address.
- R4: A store address flags a held, executed load when two conditions hold. First, the load is strictly younger: (load_tag - st_tag) mod 2^TAGW is nonzero and its top bit is 0. Second, the addresses are equal once the low LSB bits are ignored. The flag produces no output until commit.
- R5: A store does not flag loads that are older than it, equal in age to it, or not yet executed. Wrap-around of tags is honoured.
- R6: A store and an exec on the same slot in the same cycle are compared using the incoming exec address.
- R7: commit_ready is 1 only when the head load has executed. commit_valid while commit_ready is 0 has no effect.
- R8: Committing an unflagged head retires it with no trap pulse.
- R9: Committing a flagged head raises trap_valid for exactly one cycle in the next cycle, with trap_pc set to that load's PC, and empties the queue. This also applies when a store flags the head in the same cycle as the commit.
- R10: flush_valid removes every entry strictly younger than flush_tag and keeps the older ones. An allocation in a flush cycle or a trap cycle is dropped.

Key mechanism: a store compares only against executed loads younger than itself, using wrap-aware ages, and recovery is deferred to the commit of the flagged load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_tag | input | TAGW | Age tag of the allocated load |
| alloc_pc | input | PCW | PC of the allocated load |
| alloc_ready | output | 1 | Queue not full |
| alloc_slot | output | IW | Slot the next allocation will take |
| exec_valid | input | 1 | A load finished address generation |
| exec_slot | input | IW | Slot of that load |
| exec_addr | input | AW | Its address |
| st_valid | input | 1 | A store address resolved |
| st_tag | input | TAGW | Age tag of the store |
| st_addr | input | AW | Store address |
| commit_valid | input | 1 | Commit stage retires the head load |
| commit_ready | output | 1 | Head load has executed |
| flush_valid | input | 1 | Remove entries younger than flush_tag |
| flush_tag | input | TAGW | Flush point |
| trap_valid | output | 1 | Violation trap pulse |
| trap_pc | output | PCW | PC of the trapping load |

## Verification
The bench targets the age boundary: a store that is older across tag wrap must flag the load. A store of equal or younger age must not, and a reversed or non-modular compare would either miss real violations or raise false traps. It also covers a store and an exec that land in the same cycle, and a store that hits the head in the very cycle it commits. A design that looks only at registered state would let either violation retire silently. Further tests cover loads that had not yet executed when the store arrived, where a false flag would cost a needless flush. They also cover a full queue, where a lost guard would overwrite the head, and a partial flush, where a wrong tail would misplace later loads.

// File: rtl/load_violation_queue.sv
module load_violation_queue #(
  parameter int DEPTH = 32,
  parameter int AW    = 32,
  parameter int PCW   = 32,
  parameter int TAGW  = 6,
  parameter int LSB   = 2,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  input  logic [TAGW-1:0] alloc_tag,
  input  logic [PCW-1:0]  alloc_pc,
  output logic            alloc_ready,
  output logic [IW-1:0]   alloc_slot,
  input  logic            exec_valid,
  input  logic [IW-1:0]   exec_slot,
  input  logic [AW-1:0]   exec_addr,
  input  logic            st_valid,
  input  logic [TAGW-1:0] st_tag,
  input  logic [AW-1:0]   st_addr,
  input  logic            commit_valid,
  output logic            commit_ready,
  input  logic            flush_valid,
  input  logic [TAGW-1:0] flush_tag,
  output logic            trap_valid,
  output logic [PCW-1:0]  trap_pc
);

  logic [DEPTH-1:0] v, done, flag;
  logic [TAGW-1:0]  tag_q  [DEPTH];
  logic [PCW-1:0]   pc_q   [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [IW-1:0]    head;
  logic [CW-1:0]    cnt;

  function automatic logic younger(input logic [TAGW-1:0] a, input logic [TAGW-1:0] b);
    logic [TAGW-1:0] d;
    d = a - b;
    return (d != '0) && !d[TAGW-1];
  endfunction

  logic [DEPTH-1:0] hit, keep;
  logic [CW-1:0]    kept;
  logic             fire, trap_fire, alloc_fire;
  logic [IW-1:0]    tail;

  assign tail         = head + cnt[IW-1:0];
  assign alloc_slot   = tail;
  assign alloc_ready  = (cnt != CW'(DEPTH));
  assign commit_ready = v[head] & done[head];
  assign fire         = commit_valid & commit_ready;
  assign trap_fire    = fire & (flag[head] | hit[head]);
  assign alloc_fire   = alloc_valid & alloc_ready & ~flush_valid & ~trap_fire;

  always_comb begin
    kept = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = st_valid & v[i] & younger(tag_q[i], st_tag) &
               ((done[i] & (addr_q[i][AW-1:LSB] == st_addr[AW-1:LSB])) |
                (exec_valid & (exec_slot == IW'(i)) &
                 (exec_addr[AW-1:LSB] == st_addr[AW-1:LSB])));
      keep[i] = v[i] & ~(flush_valid & younger(tag_q[i], flush_tag)) &
                ~(fire & (head == IW'(i))) & ~trap_fire;
      kept = kept + CW'(keep[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v    <= '0;
      done <= '0;
      flag <= '0;
      head <= '0;
      cnt  <= '0;
      trap_valid <= 1'b0;
      trap_pc    <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && tail == IW'(i)) begin
          v[i]     <= 1'b1;
          done[i]  <= 1'b0;
          flag[i]  <= 1'b0;
          tag_q[i] <= alloc_tag;
          pc_q[i]  <= alloc_pc;
        end else begin
          v[i] <= keep[i];
          if (exec_valid && exec_slot == IW'(i) && v[i]) begin
            done[i]   <= 1'b1;
            addr_q[i] <= exec_addr;
          end
          if (hit[i]) flag[i] <= 1'b1;
        end
      end
      head       <= head + IW'(fire);
      cnt        <= kept + CW'(alloc_fire);
      trap_valid <= trap_fire;
      if (trap_fire) trap_pc <= pc_q[head];
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !commit_valid && !flush_valid) |=> cnt == $past(cnt));
  a_r7_wait_head: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready && !flush_valid) |=> head == $past(head));
  a_r9_trap_empties: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> cnt == '0);
  a_r9_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);

endmodule

// File: tb/tb_load_violation_queue.sv
module tb_load_violation_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32, AW = 32, PCW = 32, TAGW = 6, IW = 5;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0; logic [TAGW-1:0] alloc_tag = 0; logic [PCW-1:0] alloc_pc = 0;
  logic alloc_ready; logic [IW-1:0] alloc_slot;
  logic exec_valid = 0; logic [IW-1:0] exec_slot = 0; logic [AW-1:0] exec_addr = 0;
  logic st_valid = 0; logic [TAGW-1:0] st_tag = 0; logic [AW-1:0] st_addr = 0;
  logic commit_valid = 0, commit_ready;
  logic flush_valid = 0; logic [TAGW-1:0] flush_tag = 0;
  logic trap_valid; logic [PCW-1:0] trap_pc;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_violation_queue dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic [TAGW-1:0] t, input logic [PCW-1:0] pc, output logic [IW-1:0] s);
    s = alloc_slot;
    alloc_valid = 1; alloc_tag = t; alloc_pc = pc;
    tick();
    alloc_valid = 0;
  endtask

  task automatic exec(input logic [IW-1:0] s, input logic [AW-1:0] a);
    exec_valid = 1; exec_slot = s; exec_addr = a;
    tick();
    exec_valid = 0;
  endtask

  task automatic store(input logic [TAGW-1:0] t, input logic [AW-1:0] a);
    st_valid = 1; st_tag = t; st_addr = a;
    tick();
    st_valid = 0;
  endtask

  task automatic commit(string req, logic exp_trap, logic [PCW-1:0] exp_pc);
    check({req, " ready"}, commit_ready, 1);
    commit_valid = 1;
    tick();
    commit_valid = 0;
    check({req, " trap"}, trap_valid, exp_trap);
    if (exp_trap) check({req, " pc"}, trap_pc, exp_pc);
  endtask

  task automatic t_reset();
    check("R1 ready", alloc_ready, 1);
    check("R1 commit_ready", commit_ready, 0);
    check("R1 trap", trap_valid, 0);
    check("R1 slot", alloc_slot, 0);
  endtask

  task automatic t_no_match();
    logic [IW-1:0] s;
    alloc(6'd5, 32'hA0, s);
    check("R2 first slot", s, 0);
    exec(s, 32'h100);
    store(6'd3, 32'h200);
    commit("R8 no match", 0, 0);
  endtask

  task automatic t_violation();
    logic [IW-1:0] s;
    alloc(6'd10, 32'hB4, s);
    exec(s, 32'h40);
    store(6'd8, 32'h40);
    check("R4 deferred", trap_valid, 0);
    commit("R9 trap", 1, 32'hB4);
    check("R9 empty", commit_ready, 0);
    check("R9 slot", alloc_slot, s + 1'b1);
    tick();
    check("R9 one pulse", trap_valid, 0);
  endtask

  task automatic t_older_load();
    logic [IW-1:0] s;
    alloc(6'd20, 32'hC0, s);
    exec(s, 32'h80);
    store(6'd22, 32'h80);
    store(6'd20, 32'h80);
    commit("R5 older/equal", 0, 0);
  endtask

  task automatic t_not_executed();
    logic [IW-1:0] s;
    alloc(6'd30, 32'hC4, s);
    check("R7 not done", commit_ready, 0);
    commit_valid = 1; tick(); commit_valid = 0;
    check("R7 stalled trap", trap_valid, 0);
    store(6'd28, 32'h300);
    exec(s, 32'h300);
    commit("R5 unexecuted", 0, 0);
  endtask

  task automatic t_wrap();
    logic [IW-1:0] s;
    alloc(6'd2, 32'hD0, s);
    exec(s, 32'h500);
    store(6'd62, 32'h500);
    commit("R4 wrap older store", 1, 32'hD0);
    alloc(6'd62, 32'hD4, s);
    exec(s, 32'h500);
    store(6'd2, 32'h500);
    commit("R5 wrap younger store", 0, 0);
  endtask

  task automatic t_word();
    logic [IW-1:0] s;
    alloc(6'd12, 32'hE0, s);
    exec(s, 32'h104);
    store(6'd11, 32'h108);
    commit("R4 other word", 0, 0);
    alloc(6'd14, 32'hE4, s);
    exec(s, 32'h104);
    store(6'd13, 32'h106);
    commit("R4 same word", 1, 32'hE4);
  endtask

  task automatic t_same_cycle_exec();
    logic [IW-1:0] s;
    alloc(6'd16, 32'hF0, s);
    exec_valid = 1; exec_slot = s; exec_addr = 32'h700;
    st_valid = 1; st_tag = 6'd15; st_addr = 32'h700;
    tick();
    exec_valid = 0; st_valid = 0;
    commit("R6 same-cycle exec", 1, 32'hF0);
  endtask

  task automatic t_same_cycle_commit();
    logic [IW-1:0] s;
    alloc(6'd18, 32'hF4, s);
    exec(s, 32'h720);
    st_valid = 1; st_tag = 6'd17; st_addr = 32'h720;
    commit("R9 hit at commit", 1, 32'hF4);
    st_valid = 0;
  endtask

  task automatic t_second_entry();
    logic [IW-1:0] a, b;
    alloc(6'd24, 32'h100, a);
    alloc(6'd25, 32'h104, b);
    check("R2 order", b, a + 1'b1);
    exec(a, 32'h900);
    exec(b, 32'h904);
    store(6'd23, 32'h904);
    commit("R8 head clean", 0, 0);
    commit("R9 second flagged", 1, 32'h104);
  endtask

  task automatic t_flush();
    logic [IW-1:0] a, b, c, d;
    alloc(6'd40, 32'h200, a);
    alloc(6'd41, 32'h204, b);
    alloc(6'd42, 32'h208, c);
    exec(a, 32'hA00); exec(b, 32'hA04); exec(c, 32'hA08);
    flush_valid = 1; flush_tag = 6'd40;
    alloc(6'd43, 32'h20C, d);
    flush_valid = 0;
    check("R10 tail rewind", alloc_slot, a + 1'b1);
    store(6'd39, 32'hA04);
    commit("R10 survivor", 0, 0);
    check("R10 emptied", commit_ready, 0);
  endtask

  task automatic t_full();
    logic [IW-1:0] s [DEPTH];
    logic [IW-1:0] x;
    for (int i = 0; i < DEPTH; i++) alloc(6'(i), 32'h1000 + i, s[i]);
    check("R2 full", alloc_ready, 0);
    check("R2 full slot", alloc_slot, s[0]);
    alloc(6'd32, 32'hDEAD, x);
    check("R2 ignored slot", alloc_slot, s[0]);
    for (int i = 0; i < DEPTH; i++) exec(s[i], 32'h2000 + 4*i);
    store(6'd30, 32'h2000 + 4*31);
    for (int i = 0; i < DEPTH-1; i++) commit("R3 drain", 0, 0);
    commit("R3 last flagged", 1, 32'h1000 + 31);
    check("R2 ready again", alloc_ready, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_no_match();
    t_violation();
    t_older_load();
    t_not_executed();
    t_wrap();
    t_word();
    t_same_cycle_exec();
    t_same_cycle_commit();
    t_second_entry();
    t_flush();
    t_full();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule